// File: doc/BRIEF.md
# Three-wire serial word memory front end

This block is the serial slave side of a 1024-word by 16-bit serial memory. A host drives chip select, a serial clock and a serial data line. The block samples all three on a faster system clock through a synchronizer. It detects each rising edge of the serial clock and assembles a command frame. The frame is a start bit, a two-bit opcode and a ten-bit word address, and for the data-carrying writes a sixteen-bit word after that. Reads are served from a behavioural word array, and the address advances by itself for as long as clocks keep arriving. The data-out pin has an output enable, so it can be released to high impedance.

Write-type commands are checked against a write-enable latch and against an exact clock count. They take effect only when chip select drops. At that point the block hands a request to an external write sequencer and updates its own array: one word, or the whole array through a fill walk. From then on, whenever chip select is high, the data-out pin shows busy (low) or ready (high). This lasts until the host issues the next start bit.

Top module: `mw_serial_slave`

## Requirements
- R1: While chip select is low, data-out is released (output enable 0) and serial clock and data edges have no effect. Dropping chip select in the middle of a read or header abandons it and releases data-out.
- R2: After chip select rises, serial clock rising edges with data-in low are dummy clocks and are skipped. The first rising edge with data-in high is the start bit.
- R3: After the start bit, a 2-bit opcode and a 10-bit address are taken MSB first. The opcodes are 10 = read one or more words, 01 = write a word, 11 = erase a word, 00 = extended. Under 00, address bits 9..8 choose the command: 11 = enable writes, 00 = disable writes, 01 = write all words, 10 = erase all words.
- R4: For a read, once the last address bit is taken, data-out is driven and shows a low dummy bit. Bits 15 down to 0 then follow, one per serial clock rising edge. Further clocks continue with the next address without a gap, and address 1023 is followed by address 0.
- R5: After reset every word holds FFFFh. The initial fill takes one system clock per word, and start bits are ignored until it completes.
- R6: A word write takes exactly 29 serial clocks counted from the start bit (header plus 16 data bits, MSB first). It is committed when chip select falls.
- R7: A word erase takes exactly 13 serial clocks and sets the addressed word to FFFFh.
- R8: Write-all stores its 16-bit data word in every address, and erase-all stores FFFFh in every address. The data count and clock count rules are the same as in R6 and R7.
- R9: Writes are disabled after reset. Enable and disable take effect when chip select falls after the address. Any write-type command issued while writes are disabled leaves the array unchanged and raises no request.
- R10: A write-type command whose serial clock count is not exactly the required count is cancelled: no request is raised and the array is unchanged.
- R11: After an accepted write-type command, data-out is driven whenever chip select is high. It is low while the write is pending (sequencer not done, or the fill walk still running) and high once it is complete.
- R12: While data-out shows ready, a data-in high at a serial clock rising edge is a new start bit, and data-out is released at once. While busy, data-in highs are ignored.
- R13: An accepted write-type command raises a one-cycle request carrying the kind (0 = word write, 1 = word erase, 2 = write all, 3 = erase all), the address and the data. The pending state ends on a done pulse from the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select from the host, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out enable (0 = high impedance) |
| wreq_o | output | 1 | One-cycle write request to the sequencer |
| wreq_kind_o | output | 2 | Request kind: 0 word write, 1 word erase, 2 write all, 3 erase all |
| wreq_addr_o | output | 10 | Word address of the request |
| wreq_data_o | output | 16 | Data word of the request |
| wseq_done_i | input | 1 | Pulse from the sequencer when the write time has elapsed |

## Verification
The embedded assertions watch several rules on every cycle. The command logic must fall back to hunting for a start bit whenever chip select is low. A request may appear only with writes enabled and chip select low, and never while the fill walk runs. The read address must wrap from the top word to zero. A start edge seen while busy must change nothing. Other behaviour can only be shown by the bench's scenarios: the exact bit order on data-out across word and wrap boundaries, the cancellation of miscounted frames, and the busy-to-ready sequence during verify with the release of data-out on a new start bit. The array contents after word writes, erases and whole-array fills are also shown this way, and the bench compares them against its own model.

// File: rtl/mw_pkg.sv
package mw_pkg;
   // opcode field values (first two bits after the start bit)
   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   // extended sub-commands carried in the two top address bits
   localparam logic [1:0] EXT_WDIS = 2'b00;
   localparam logic [1:0] EXT_WALL = 2'b01;
   localparam logic [1:0] EXT_EALL = 2'b10;
   localparam logic [1:0] EXT_WEN  = 2'b11;

   typedef enum logic [2:0] {
      K_READ, K_WRITE, K_ERASE, K_WALL, K_EALL, K_WEN, K_WDIS
   } cmd_e;

   typedef enum logic [1:0] {
      RQ_WORD_WR = 2'd0,
      RQ_WORD_ER = 2'd1,
      RQ_ALL_WR  = 2'd2,
      RQ_ALL_ER  = 2'd3
   } req_e;

   typedef enum logic [2:0] {
      S_HUNT, S_HDR, S_READ, S_DATA, S_TAIL
   } st_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   output logic              fill_busy
);
   import mw_pkg::*;
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];
   logic [ADDR_W-1:0] fill_ptr;
   logic [DATA_W-1:0] fill_val;
   logic              is_all;
   logic              is_erase;

   assign is_all   = (req_kind == RQ_ALL_WR) || (req_kind == RQ_ALL_ER);
   assign is_erase = (req_kind == RQ_WORD_ER) || (req_kind == RQ_ALL_ER);

   // fill walk: runs once after reset (all ones) and for each whole-array request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_busy <= 1'b1;
         fill_ptr  <= '0;
         fill_val  <= '1;
      end else if (fill_busy) begin
         fill_ptr <= fill_ptr + 1'b1;
         if (fill_ptr == {ADDR_W{1'b1}}) fill_busy <= 1'b0;
      end else if (req_valid && is_all) begin
         fill_busy <= 1'b1;
         fill_ptr  <= '0;
         fill_val  <= is_erase ? '1 : req_data;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_busy)
         mem[fill_ptr] <= fill_val;
      else if (req_valid && !is_all)
         mem[req_addr] <= is_erase ? '1 : req_data;
   end

   assign rd_word = mem[rd_addr];

   // R13: the command logic only accepts frames while idle, so no request meets a fill
   a_r13_no_req_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !fill_busy);

   // R8: once started, a fill walk keeps going until the last word
   a_r8_fill_runs_to_end: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_busy && fill_ptr != {ADDR_W{1'b1}}) |=> fill_busy);
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl,
   input  logic              cs_fall,
   input  logic              sk_rise,
   input  logic              di_lvl,
   input  logic              fill_busy,
   input  logic              seq_done,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_port_addr,
   output logic              rd_oe,
   output logic              rd_bit,
   output logic              verify_on,
   output logic              stat_ready,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data
);
   import mw_pkg::*;

   localparam int HDR_BITS = 2 + ADDR_W;
   localparam int HDR_CLKS = 1 + HDR_BITS;
   localparam int WR_CLKS  = HDR_CLKS + DATA_W;
   localparam int CNT_W    = $clog2(WR_CLKS + 2);
   localparam int BIT_W    = $clog2(DATA_W);

   st_e               st;
   cmd_e              kind;
   logic [HDR_BITS-1:0] hdr;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] dat;
   logic              wen;
   logic              pend;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_dummy;
   logic [BIT_W-1:0]  bit_ptr;

   logic [HDR_BITS-1:0] full_hdr;
   logic [1:0]          op;
   logic [ADDR_W-1:0]   hdr_addr;
   logic [1:0]          ext;
   logic [CNT_W-1:0]    cnt_inc;
   logic                rd_adv;
   logic                len_ok;
   logic                is_wr;

   assign full_hdr   = {hdr[HDR_BITS-2:0], di_lvl};
   assign op         = full_hdr[HDR_BITS-1 -: 2];
   assign hdr_addr   = full_hdr[ADDR_W-1:0];
   assign ext        = hdr_addr[ADDR_W-1 -: 2];
   assign cnt_inc    = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
   assign stat_ready = !pend && !fill_busy;
   assign rd_adv     = !rd_dummy && (bit_ptr == '0);
   assign rd_port_addr = rd_adv ? rd_addr + 1'b1 : rd_addr;
   assign is_wr      = (kind == K_WRITE) || (kind == K_WALL) ||
                       (kind == K_ERASE) || (kind == K_EALL);

   always_comb begin
      unique case (kind)
         K_WRITE, K_WALL: len_ok = (cnt == CNT_W'(WR_CLKS));
         K_ERASE, K_EALL: len_ok = (cnt == CNT_W'(HDR_CLKS));
         default:         len_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_HUNT;
         kind      <= K_READ;
         hdr       <= '0;
         cnt       <= '0;
         cmd_addr  <= '0;
         dat       <= '0;
         wen       <= 1'b0;
         pend      <= 1'b0;
         verify_on <= 1'b0;
         rd_addr   <= '0;
         rd_oe     <= 1'b0;
         rd_bit    <= 1'b0;
         rd_dummy  <= 1'b0;
         bit_ptr   <= '0;
         req_valid <= 1'b0;
         req_kind  <= '0;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         req_valid <= 1'b0;
         if (seq_done) pend <= 1'b0;

         if (!cs_lvl) begin
            st    <= S_HUNT;
            rd_oe <= 1'b0;
            if (cs_fall && (st == S_DATA || st == S_TAIL)) begin
               if (kind == K_WEN) wen <= 1'b1;
               else if (kind == K_WDIS) wen <= 1'b0;
               else if (is_wr && wen && len_ok) begin
                  req_valid <= 1'b1;
                  req_addr  <= cmd_addr;
                  req_data  <= dat;
                  pend      <= 1'b1;
                  verify_on <= 1'b1;
                  unique case (kind)
                     K_WRITE: req_kind <= RQ_WORD_WR;
                     K_ERASE: req_kind <= RQ_WORD_ER;
                     K_WALL:  req_kind <= RQ_ALL_WR;
                     default: req_kind <= RQ_ALL_ER;
                  endcase
               end
            end
         end else if (sk_rise) begin
            unique case (st)
               S_HUNT: begin
                  if (di_lvl && stat_ready) begin
                     st        <= S_HDR;
                     cnt       <= CNT_W'(1);
                     hdr       <= '0;
                     verify_on <= 1'b0;
                  end
               end
               S_HDR: begin
                  hdr <= full_hdr;
                  cnt <= cnt_inc;
                  if (cnt == CNT_W'(HDR_CLKS - 1)) begin
                     cmd_addr <= hdr_addr;
                     unique case (op)
                        OP_READ: begin
                           kind     <= K_READ;
                           st       <= S_READ;
                           rd_addr  <= hdr_addr;
                           rd_oe    <= 1'b1;
                           rd_bit   <= 1'b0;
                           rd_dummy <= 1'b1;
                        end
                        OP_WRITE: begin
                           kind <= K_WRITE;
                           st   <= S_DATA;
                        end
                        OP_ERASE: begin
                           kind <= K_ERASE;
                           st   <= S_TAIL;
                        end
                        default: begin
                           unique case (ext)
                              EXT_WALL: begin kind <= K_WALL; st <= S_DATA; end
                              EXT_EALL: begin kind <= K_EALL; st <= S_TAIL; end
                              EXT_WEN:  begin kind <= K_WEN;  st <= S_TAIL; end
                              default:  begin kind <= K_WDIS; st <= S_TAIL; end
                           endcase
                        end
                     endcase
                  end
               end
               S_DATA: begin
                  dat <= {dat[DATA_W-2:0], di_lvl};
                  cnt <= cnt_inc;
               end
               S_TAIL: begin
                  cnt <= cnt_inc;
               end
               default: begin // S_READ
                  if (rd_dummy) begin
                     rd_dummy <= 1'b0;
                     rd_bit   <= rd_word[DATA_W-1];
                     bit_ptr  <= BIT_W'(DATA_W - 1);
                  end else if (bit_ptr == '0) begin
                     rd_addr  <= rd_addr + 1'b1;
                     rd_bit   <= rd_word[DATA_W-1];
                     bit_ptr  <= BIT_W'(DATA_W - 1);
                  end else begin
                     rd_bit   <= rd_word[bit_ptr - 1'b1];
                     bit_ptr  <= bit_ptr - 1'b1;
                  end
               end
            endcase
         end
      end
   end

   // R1: deselect always sends the command logic back to hunting with data-out released
   a_r1_deselect_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_lvl |=> (st == S_HUNT && !rd_oe));

   // R9: a write request can only leave while writes are enabled
   a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> wen);

   // R6: requests are only issued after chip select has dropped
   a_r6_req_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !cs_lvl);

   // R4: the read pointer wraps from the top word to zero
   a_r4_read_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl && sk_rise && st == S_READ && !rd_dummy && bit_ptr == '0 &&
       rd_addr == {ADDR_W{1'b1}}) |=> (rd_addr == '0));

   // R12: a start-like edge while busy leaves hunting state and status untouched
   a_r12_busy_ignores_di: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl && sk_rise && st == S_HUNT && !stat_ready && !seq_done) |=>
      (st == S_HUNT && verify_on == $past(verify_on)));
endmodule

// File: rtl/mw_serial_slave.sv
module mw_serial_slave #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sk_i,
   input  logic              di_i,
   output logic              do_o,
   output logic              do_oe_o,
   output logic              wreq_o,
   output logic [1:0]        wreq_kind_o,
   output logic [ADDR_W-1:0] wreq_addr_o,
   output logic [DATA_W-1:0] wreq_data_o,
   input  logic              wseq_done_i
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              cs_s, sk_s, di_s;
   logic              cs_q, sk_q;
   logic              sk_rise, cs_fall;
   logic [ADDR_W-1:0] rd_port_addr;
   logic [DATA_W-1:0] rd_word;
   logic              fill_busy;
   logic              rd_oe, rd_bit, verify_on, stat_ready;

   mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sk_i, di_i}),
      .q_o   (pins_s)
   );

   assign {cs_s, sk_s, di_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         sk_q <= 1'b0;
      end else begin
         cs_q <= cs_s;
         sk_q <= sk_s;
      end
   end

   assign sk_rise = sk_s & ~sk_q;
   assign cs_fall = cs_q & ~cs_s;

   mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_lvl       (cs_s),
      .cs_fall      (cs_fall),
      .sk_rise      (sk_rise),
      .di_lvl       (di_s),
      .fill_busy    (fill_busy),
      .seq_done     (wseq_done_i),
      .rd_word      (rd_word),
      .rd_port_addr (rd_port_addr),
      .rd_oe        (rd_oe),
      .rd_bit       (rd_bit),
      .verify_on    (verify_on),
      .stat_ready   (stat_ready),
      .req_valid    (wreq_o),
      .req_kind     (wreq_kind_o),
      .req_addr     (wreq_addr_o),
      .req_data     (wreq_data_o)
   );

   mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (wreq_o),
      .req_kind  (wreq_kind_o),
      .req_addr  (wreq_addr_o),
      .req_data  (wreq_data_o),
      .rd_addr   (rd_port_addr),
      .rd_word   (rd_word),
      .fill_busy (fill_busy)
   );

   assign do_oe_o = cs_s & (verify_on | rd_oe);
   assign do_o    = verify_on ? stat_ready : rd_bit;
endmodule

// File: tb/tb_mw_serial_slave.sv
module tb_mw_serial_slave;
   localparam int H       = 6;
   localparam int WORDS   = 1024;
   localparam int SEQ_DLY = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic        do_o, do_oe_o, wreq_o;
   logic [1:0]  wreq_kind_o;
   logic [9:0]  wreq_addr_o;
   logic [15:0] wreq_data_o;
   logic        wseq_done = 1'b0;

   int tests = 0, fails = 0;
   int req_cnt = 0;
   logic [1:0]  last_kind;
   logic [9:0]  last_addr;
   logic [15:0] last_data;
   int          seq_timer = 0;
   logic [15:0] model [WORDS];

   always #2 clk = ~clk;

   mw_serial_slave dut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .do_o(do_o), .do_oe_o(do_oe_o), .wreq_o(wreq_o),
      .wreq_kind_o(wreq_kind_o), .wreq_addr_o(wreq_addr_o),
      .wreq_data_o(wreq_data_o), .wseq_done_i(wseq_done)
   );

   // write sequencer model: done pulse a fixed time after each request
   always @(posedge clk) begin
      wseq_done <= 1'b0;
      if (wreq_o) begin
         req_cnt   <= req_cnt + 1;
         last_kind <= wreq_kind_o;
         last_addr <= wreq_addr_o;
         last_data <= wreq_data_o;
         seq_timer <= SEQ_DLY;
      end else if (seq_timer != 0) begin
         seq_timer <= seq_timer - 1;
         if (seq_timer == 1) wseq_done <= 1'b1;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: run did not complete (actual timeout, expected finish)");
      summary();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sk_bit(input logic b, output logic sd, output logic so);
      di = b; sk = 1'b0;
      repeat (H) @(negedge clk);
      sd = do_o; so = do_oe_o;
      sk = 1'b1;
      repeat (H) @(negedge clk);
      sk = 1'b0;
   endtask

   task automatic cs_up();
      sk = 1'b0; di = 1'b0; cs = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_down();
      sk = 1'b0; di = 1'b0;
      repeat (2) @(negedge clk);
      cs = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [9:0] addr, input int ndummy);
      logic sd, so;
      for (int i = 0; i < ndummy; i++) sk_bit(1'b0, sd, so);
      sk_bit(1'b1, sd, so);
      for (int i = 1; i >= 0; i--) sk_bit(op[i], sd, so);
      for (int i = 9; i >= 0; i--) sk_bit(addr[i], sd, so);
   endtask

   // full frame: header then nbits data bits (bits beyond 16 are sent as zero)
   task automatic cmd(input logic [1:0] op, input logic [9:0] addr,
                      input logic [15:0] data, input int nbits);
      logic sd, so;
      cs_up();
      send_hdr(op, addr, 0);
      for (int i = 0; i < nbits; i++)
         sk_bit((i < 16) ? data[15-i] : 1'b0, sd, so);
      cs_down();
   endtask

   task automatic do_read(input logic [9:0] addr, input int n, input int ndummy, input string req);
      logic sd, so;
      logic [15:0] w;
      cs_up();
      send_hdr(2'b10, addr, ndummy);
      sk_bit(1'b0, sd, so);
      chk(req, {30'd0, so, sd}, 32'h2);        // driven, low dummy bit
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int b = 0; b < 16; b++) begin
            sk_bit(1'b0, sd, so);
            w = {w[14:0], sd};
         end
         chk(req, {16'd0, w}, {16'd0, model[(int'(addr) + k) % WORDS]});
      end
      cs_down();
      chk("R1", {31'd0, do_oe_o}, 32'd0);
   endtask

   task automatic wait_ready(input string req);
      bit seen = 0;
      cs_up();
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (do_oe_o && do_o) begin seen = 1; break; end
      end
      chk(req, {31'd0, seen}, 32'd1);
      cs_down();
   endtask

   initial begin
      logic sd, so;
      int n0;
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;

      repeat (5) @(negedge clk);
      chk("R1", {30'd0, do_oe_o, wreq_o}, 32'd0);
      rst_n = 1'b1;
      repeat (1300) @(negedge clk);

      // standby: clocks with data high while deselected do nothing
      for (int i = 0; i < 8; i++) begin
         di = 1'b1; sk = 1'b1; repeat (3) @(negedge clk);
         sk = 1'b0; repeat (3) @(negedge clk);
         chk("R1", {31'd0, do_oe_o}, 32'd0);
      end
      di = 1'b0;

      // R5 reset contents, R2 dummy clocks, R3/R4 read frame
      do_read(10'd5, 1, 3, "R5");
      do_read(10'd900, 2, 0, "R4");

      // R9 writes disabled after reset
      n0 = req_cnt;
      cmd(2'b01, 10'd5, 16'h1234, 16);
      chk("R9", req_cnt, n0);
      do_read(10'd5, 1, 0, "R9");

      // enable, then word write
      cmd(2'b00, 10'b11_0000_0000, 16'h0, 0);
      n0 = req_cnt;
      cmd(2'b01, 10'd7, 16'hA5C3, 16);
      chk("R13", req_cnt, n0 + 1);
      chk("R13", {14'd0, last_kind, 6'd0, last_addr}, {14'd0, 2'd0, 6'd0, 10'd7});
      chk("R13", {16'd0, last_data}, 32'h0000A5C3);
      model[7] = 16'hA5C3;

      // verify: busy low, data-in high ignored while busy, then ready, then new start
      cs_up();
      chk("R11", {30'd0, do_oe_o, do_o}, 32'h2);
      sk_bit(1'b1, sd, so);
      @(negedge clk);
      chk("R12", {30'd0, do_oe_o, do_o}, 32'h2);
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (do_o) break;
      end
      chk("R11", {30'd0, do_oe_o, do_o}, 32'h3);
      sk_bit(1'b1, sd, so);
      @(negedge clk);
      chk("R12", {31'd0, do_oe_o}, 32'd0);
      cs_down();
      do_read(10'd7, 1, 0, "R6");

      // R6 sweep of word writes across the array
      for (int i = 0; i < 12; i++) begin
         logic [9:0]  a;
         logic [15:0] d;
         a = 10'((i * 89 + 3) % WORDS);
         d = 16'(int'(a) * 611) ^ 16'hC35A;
         cmd(2'b01, a, d, 16);
         wait_ready("R6");
         model[a] = d;
      end
      for (int i = 0; i < 12; i++)
         do_read(10'((i * 89 + 3) % WORDS), 1, 0, "R6");

      // R10 clock count mismatch
      n0 = req_cnt;
      cmd(2'b01, 10'd9, 16'h0F0F, 17);
      chk("R10", req_cnt, n0);
      cmd(2'b01, 10'd9, 16'h0F0F, 15);
      chk("R10", req_cnt, n0);
      cmd(2'b11, 10'd7, 16'h0, 1);
      chk("R10", req_cnt, n0);
      do_read(10'd7, 1, 0, "R10");

      // R7 word erase
      cmd(2'b11, 10'd7, 16'h0, 0);
      chk("R7", req_cnt, n0 + 1);
      chk("R7", {30'd0, last_kind}, 32'd1);
      wait_ready("R7");
      model[7] = 16'hFFFF;
      do_read(10'd7, 1, 0, "R7");

      // R8 write-all, then R4 wrap across the top of the array
      cmd(2'b00, 10'b01_1010_1010, 16'h3C96, 16);
      chk("R8", {30'd0, last_kind}, 32'd2);
      wait_ready("R8");
      for (int i = 0; i < WORDS; i++) model[i] = 16'h3C96;
      cmd(2'b01, 10'd1023, 16'h1111, 16); wait_ready("R6"); model[1023] = 16'h1111;
      cmd(2'b01, 10'd0,    16'h2222, 16); wait_ready("R6"); model[0]    = 16'h2222;
      do_read(10'd1021, 5, 1, "R4");

      // R8 erase-all
      cmd(2'b00, 10'b10_0101_0101, 16'h0, 0);
      chk("R8", {30'd0, last_kind}, 32'd3);
      wait_ready("R8");
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      do_read(10'd1022, 3, 0, "R8");

      // R9 disable again
      cmd(2'b00, 10'b00_0000_0000, 16'h0, 0);
      n0 = req_cnt;
      cmd(2'b01, 10'd4, 16'h0000, 16);
      chk("R9", req_cnt, n0);
      do_read(10'd4, 1, 0, "R9");

      // R1 abort a read in mid-word
      cs_up();
      send_hdr(2'b10, 10'd3, 0);
      for (int i = 0; i < 5; i++) sk_bit(1'b0, sd, so);
      chk("R1", {31'd0, so}, 32'd1);
      cs_down();
      chk("R1", {31'd0, do_oe_o}, 32'd0);
      do_read(10'd3, 1, 0, "R3");

      summary();
   end
endmodule